// File: doc/BRIEF.md
# I2C Interrupt Event Classifier

This block turns the raw status flags of a byte-level I2C controller into one event for the transfer sequencer that drives that controller. When the controller raises its interrupt-pending flag, the block takes a single snapshot of four flags: addressed-as-slave, arbitration lost, received acknowledge, and the controller's transmit-mode bit. A fixed priority reduces that snapshot to one event code. The code comes out for one cycle with a valid strobe, together with the clear strobes the controller needs for that kind of event.

Each interrupt produces exactly one event. After classifying an interrupt, the block will not accept the pending flag again until it has seen that flag low on at least one clock edge. A pending flag that the controller has not yet dropped is therefore never counted twice. The flags are captured on one edge, so changes made to them after that edge cannot alter or split the event.

Top module: `irq_evt_classifier`

## Requirements
- R1: While reset is high and on the first cycle after it, evt_valid, evt_code, evt_onehot and all three clear strobes are zero.
- R2: If irq_pend is low on a capture edge, no event follows and no clear strobe is issued; while not valid, evt_code reads 0 (none).
- R3: Among simultaneous flags, the priority is st_slave (code 1), then st_arb (code 2), then the transmit-mode outcome, then data received.
- R4: With ctl_tx high and neither st_slave nor st_arb set, st_rxack high gives NACK (code 4) and st_rxack low gives ACK (code 3).
- R5: With ctl_tx low and neither st_slave nor st_arb set, the event is data received (code 5).
- R6: clr_arb pulses in the same cycle as evt_valid exactly when the code is 2, and at no other time.
- R7: ctl_rewrite pulses in the same cycle as evt_valid exactly when the code is 1, and at no other time.
- R8: clr_pend pulses together with evt_valid for every event and is low whenever evt_valid is low.
- R9: evt_valid and every clear strobe last exactly one cycle per event.
- R10: The flags are sampled on the edge at which irq_pend is first seen high while armed. The event appears after the following edge. Flag changes after the sampling edge do not affect it.
- R11: One interrupt gives one event. If irq_pend stays high, no further event occurs until irq_pend has been low on at least one edge.
- R12: evt_onehot has bit (code-1) set while valid and is all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | 1 | Controller interrupt-pending flag |
| st_slave | input | 1 | Addressed-as-slave status flag |
| st_arb | input | 1 | Arbitration-lost status flag |
| st_rxack | input | 1 | Received-acknowledge bit (high means no acknowledge) |
| ctl_tx | input | 1 | Controller transmit-mode bit |
| evt_valid | output | 1 | One-cycle strobe marking a classified event |
| evt_code | output | 3 | Event code: 0 none, 1 slave, 2 arb-lost, 3 ACK, 4 NACK, 5 data received |
| evt_onehot | output | 5 | One-hot form of the event, bit code-1 |
| clr_pend | output | 1 | Clear strobe for the interrupt-pending flag |
| clr_arb | output | 1 | Clear strobe for the arbitration-lost flag |
| ctl_rewrite | output | 1 | Control-register rewrite strobe that clears the slave condition |

## Verification
The flags are captured on the edge at which an armed irq_pend is seen high. The event code, the one-hot vector and the clear strobes are all due one edge later, so each interrupt is checked shortly after the second rising edge that follows stimulus applied at a falling edge. One edge further on, the bench checks that every output has dropped back to zero. Between the capture edge and the check edge the bench scrambles the flags, which tests that the snapshot holds. It also keeps irq_pend high for many cycles to show that only one event is issued until the flag has been low.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

  localparam int EVT_W   = 3;
  localparam int NUM_EVT = 5;

  typedef enum logic [EVT_W-1:0] {
    EV_NONE  = 3'd0,
    EV_SLAVE = 3'd1,
    EV_ARB   = 3'd2,
    EV_ACK   = 3'd3,
    EV_NACK  = 3'd4,
    EV_RX    = 3'd5
  } ev_code_t;

  typedef struct packed {
    logic slave;
    logic arb;
    logic rxack;
    logic tx;
  } flag_snap_t;

endpackage

// File: rtl/irq_evt_capture.sv
module irq_evt_capture
  import irq_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_pend,
  input  flag_snap_t flags_in,
  output logic       snap_vld,
  output flag_snap_t snap
);

  logic armed;
  logic take;

  assign take = irq_pend && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b1;
      snap_vld <= 1'b0;
      snap     <= '0;
    end else begin
      snap_vld <= take;
      if (take) begin
        snap  <= flags_in;
        armed <= 1'b0;
      end else if (!irq_pend) begin
        armed <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_evt_prio.sv
module irq_evt_prio
  import irq_evt_pkg::*;
(
  input  logic       snap_vld,
  input  flag_snap_t snap,
  output ev_code_t   code
);

  always_comb begin
    if (!snap_vld)       code = EV_NONE;
    else if (snap.slave) code = EV_SLAVE;
    else if (snap.arb)   code = EV_ARB;
    else if (snap.tx)    code = snap.rxack ? EV_NACK : EV_ACK;
    else                 code = EV_RX;
  end

endmodule

// File: rtl/irq_evt_issue.sv
module irq_evt_issue
  import irq_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ev_code_t           code,
  output logic               evt_valid,
  output logic [EVT_W-1:0]   evt_code,
  output logic [NUM_EVT-1:0] evt_onehot,
  output logic               clr_pend,
  output logic               clr_arb,
  output logic               ctl_rewrite
);

  logic any;
  assign any = (code != EV_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid   <= 1'b0;
      evt_code    <= '0;
      clr_pend    <= 1'b0;
      clr_arb     <= 1'b0;
      ctl_rewrite <= 1'b0;
    end else begin
      evt_valid   <= any;
      evt_code    <= code;
      clr_pend    <= any;
      clr_arb     <= (code == EV_ARB);
      ctl_rewrite <= (code == EV_SLAVE);
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_oh
    always_ff @(posedge clk) begin
      if (rst) evt_onehot[i] <= 1'b0;
      else     evt_onehot[i] <= (code == ev_code_t'(i + 1));
    end
  end

endmodule

// File: rtl/irq_evt_classifier.sv
module irq_evt_classifier
  import irq_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               irq_pend,
  input  logic               st_slave,
  input  logic               st_arb,
  input  logic               st_rxack,
  input  logic               ctl_tx,
  output logic               evt_valid,
  output logic [EVT_W-1:0]   evt_code,
  output logic [NUM_EVT-1:0] evt_onehot,
  output logic               clr_pend,
  output logic               clr_arb,
  output logic               ctl_rewrite
);

  flag_snap_t flags_in;
  flag_snap_t snap;
  logic       snap_vld;
  ev_code_t   code;

  assign flags_in = '{slave: st_slave, arb: st_arb, rxack: st_rxack, tx: ctl_tx};

  irq_evt_capture u_cap (
    .clk      (clk),
    .rst      (rst),
    .irq_pend (irq_pend),
    .flags_in (flags_in),
    .snap_vld (snap_vld),
    .snap     (snap)
  );

  irq_evt_prio u_prio (
    .snap_vld (snap_vld),
    .snap     (snap),
    .code     (code)
  );

  irq_evt_issue u_iss (
    .clk         (clk),
    .rst         (rst),
    .code        (code),
    .evt_valid   (evt_valid),
    .evt_code    (evt_code),
    .evt_onehot  (evt_onehot),
    .clr_pend    (clr_pend),
    .clr_arb     (clr_arb),
    .ctl_rewrite (ctl_rewrite)
  );

endmodule

// File: rtl/irq_evt_classifier_chk.sv
module irq_evt_classifier_chk
  import irq_evt_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               irq_pend,
  input logic               st_slave,
  input logic               st_arb,
  input logic               st_rxack,
  input logic               ctl_tx,
  input logic               evt_valid,
  input logic [EVT_W-1:0]   evt_code,
  input logic [NUM_EVT-1:0] evt_onehot,
  input logic               clr_pend,
  input logic               clr_arb,
  input logic               ctl_rewrite
);

  // R2
  no_pend_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(irq_pend, 2) |-> !evt_valid);

  // R2
  idle_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |-> evt_code == 3'd0);

  // R4
  tx_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid && !$past(st_slave, 2) && !$past(st_arb, 2) && $past(ctl_tx, 2)
      |-> evt_code == ($past(st_rxack, 2) ? 3'd4 : 3'd3));

  // R6
  arb_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_arb == (evt_valid && evt_code == 3'd2));

  // R7
  slave_rewrite_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_rewrite == (evt_valid && evt_code == 3'd1));

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_pend == evt_valid);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> !evt_valid);

  // R12
  onehot_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(evt_onehot) == (evt_valid ? 1 : 0));

endmodule

bind irq_evt_classifier irq_evt_classifier_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_pend    (irq_pend),
  .st_slave    (st_slave),
  .st_arb      (st_arb),
  .st_rxack    (st_rxack),
  .ctl_tx      (ctl_tx),
  .evt_valid   (evt_valid),
  .evt_code    (evt_code),
  .evt_onehot  (evt_onehot),
  .clr_pend    (clr_pend),
  .clr_arb     (clr_arb),
  .ctl_rewrite (ctl_rewrite)
);

// File: tb/irq_evt_classifier_test.sv
`timescale 1ns/100ps
module irq_evt_classifier_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_pend = 1'b0, st_slave = 1'b0, st_arb = 1'b0, st_rxack = 1'b0, ctl_tx = 1'b0;
  logic       evt_valid, clr_pend, clr_arb, ctl_rewrite;
  logic [2:0] evt_code;
  logic [4:0] evt_onehot;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  irq_evt_classifier uut (
    .clk(clk), .rst(rst), .irq_pend(irq_pend), .st_slave(st_slave),
    .st_arb(st_arb), .st_rxack(st_rxack), .ctl_tx(ctl_tx),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_onehot(evt_onehot),
    .clr_pend(clr_pend), .clr_arb(clr_arb), .ctl_rewrite(ctl_rewrite)
  );

  function automatic int exp_code(bit s, bit a, bit k, bit t);
    if (s) return 1;
    if (a) return 2;
    if (t) return k ? 4 : 3;
    return 5;
  endfunction

  function automatic string code_req(int c);
    if (c <= 2) return "R3";
    if (c <= 4) return "R4";
    return "R5";
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet(string req);
    chk(evt_valid == 0 && evt_code == 0 && evt_onehot == 0 &&
        clr_pend == 0 && clr_arb == 0 && ctl_rewrite == 0, req,
        {evt_valid, evt_code, evt_onehot, clr_pend, clr_arb, ctl_rewrite}, 0);
  endtask

  // One interrupt: flags present at the capture edge, scrambled afterwards (R10).
  task automatic one_irq(bit s, bit a, bit k, bit t, bit scramble);
    int e;
    e = exp_code(s, a, k, t);
    @(negedge clk);
    irq_pend = 1; st_slave = s; st_arb = a; st_rxack = k; ctl_tx = t;
    @(posedge clk);
    @(negedge clk);
    if (scramble) begin
      st_slave = ~s; st_arb = ~a; st_rxack = ~k; ctl_tx = ~t;
    end
    @(posedge clk); #1;
    chk(evt_valid == 1, "R10", evt_valid, 1);
    chk(evt_code == e, code_req(e), evt_code, e);
    chk(clr_pend == 1, "R8", clr_pend, 1);
    chk(clr_arb == (e == 2), "R6", clr_arb, e == 2);
    chk(ctl_rewrite == (e == 1), "R7", ctl_rewrite, e == 1);
    chk(evt_onehot == 5'(1 << (e - 1)), "R12", evt_onehot, 1 << (e - 1));
    @(negedge clk);
    irq_pend = 0;
    @(posedge clk); #1;
    quiet("R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    quiet("R1");
    @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    quiet("R1");

    // pending low with every flag set: nothing happens (R2)
    @(negedge clk);
    st_slave = 1; st_arb = 1; st_rxack = 1; ctl_tx = 1;
    repeat (4) begin
      @(posedge clk); #1;
      quiet("R2");
    end

    // directed priority corners
    one_irq(1, 1, 1, 1, 1);  // R3 slave beats all
    one_irq(0, 1, 1, 1, 1);  // R3 arb beats tx
    one_irq(0, 1, 0, 0, 0);  // R6
    one_irq(1, 0, 0, 0, 0);  // R7
    one_irq(0, 0, 1, 1, 1);  // R4 NACK
    one_irq(0, 0, 0, 1, 1);  // R4 ACK
    one_irq(0, 0, 1, 0, 1);  // R5 rxack ignored when not transmitting
    one_irq(0, 0, 0, 0, 0);  // R5

    // pending held high: a single event only (R11)
    begin
      int cnt;
      cnt = 0;
      @(negedge clk);
      irq_pend = 1; st_slave = 0; st_arb = 0; ctl_tx = 0;
      repeat (12) begin
        @(posedge clk); #1;
        if (evt_valid) cnt++;
      end
      chk(cnt == 1, "R11", cnt, 1);
      @(negedge clk);
      irq_pend = 0;
      repeat (2) @(posedge clk);
      #1;
      quiet("R11");
    end

    // rearm after a low edge gives a new event (R11)
    one_irq(0, 1, 0, 0, 1);

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      one_irq(r[0], r[1], r[2], r[3], 1'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule